// File: doc/BRIEF.md
# Floating-point status and exception register

This block holds the 32-bit status and control word that sits beside a floating-point datapath. Software loads it through a port with a per-bit write mask. The arithmetic units report the outcome of every finished operation as a five-bit raw exception vector. From that vector the register rebuilds its flag field, gathers the exceptions into a cause field, and raises a one-cycle trap request when a cause bit meets a set enable bit. The register also decodes two controls for the datapath: the rounding direction and a flush-to-zero control for denormals. The same event port takes comparison results and keeps the condition bit T.

The word is laid out as follows. Bits 1:0 hold the rounding mode. Bits 6:2 hold the flags. Bits 11:7 hold the enables. Bits 17:12 hold the cause, of which bits 16:12 track the five exceptions and bit 17 can only be set by software. Bit 18 holds the denormal control, and bits 31:19 always read zero. Inside each five-bit group the exception positions are: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. The event port has no back-pressure. It has no ready signal, and it accepts an event in every cycle in which `ev_valid` is high. A software load in the same cycle wins and the event is dropped.

Top module: `fp_status_reg`

## Requirements
- R1: A software load writes `(csr_q & ~sw_wmask) | (sw_wdata & sw_wmask)` with bits 31:19 forced to zero, and the result is visible on `csr_q` after the next clock edge. Reset clears the whole word.
- R2: `round_trunc` is high exactly when bits 1:0 hold 2'b01 (truncate). The codes 00, 10 and 11 select round-to-nearest-even, and `round_trunc` is then low.
- R3: `flush_zero` follows bit 18 of the register.
- R4: An arithmetic event (`ev_kind` 0 or 3) replaces the flag field 6:2 with `ev_exc`, so flags from earlier operations are cleared even when `ev_exc` is zero.
- R5: When `ev_exc` is non-zero, its bits are ORed into cause bits 16:12. When it is zero the cause field is unchanged, and cause bits are cleared only by a software load.
- R6: When an event with a non-zero `ev_exc` leaves `(cause[16:12] & enable[11:7])` non-zero, `trap_req` is high in the cycle after the event edge. This includes a cause bit left over from an earlier operation. When no enable matches, no trap is raised.
- R7: A compare event (`ev_kind` 1 = equal, 2 = greater) with an ordered relation (`ev_rel` 0 less, 1 equal, 2 greater) sets T when the tested relation holds and clears it otherwise. It leaves the register word unchanged.
- R8: A compare with `ev_rel` 3 (unordered) leaves T unchanged and updates flags, cause and trap from `ev_exc` exactly as an arithmetic event does.
- R9: A software load in the same cycle as an event takes priority. The event has no effect on the word, on T or on `trap_req`.
- R10: `trap_req` lasts one cycle per trapping event. While it is high, `trap_vec` shows 12'h120; otherwise `trap_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software load strobe |
| sw_wdata | input | 32 | Software load data |
| sw_wmask | input | 32 | Per-bit write mask for the load |
| ev_valid | input | 1 | Operation or compare completed this cycle |
| ev_kind | input | 2 | 0/3 arithmetic, 1 compare-equal, 2 compare-greater |
| ev_rel | input | 2 | Compare relation: 0 less, 1 equal, 2 greater, 3 unordered |
| ev_exc | input | 5 | Raw exception vector of the event |
| csr_q | output | 32 | Current register word |
| round_trunc | output | 1 | Datapath rounds toward zero when high |
| flush_zero | output | 1 | Datapath flushes denormals to zero when high |
| trap_req | output | 1 | One-cycle floating-point exception request |
| trap_vec | output | 12 | Exception vector code while `trap_req` is high |
| t_bit | output | 1 | Comparison condition bit |

## Verification
The bench follows an event with no exceptions after events that had them. A design that only accumulated flags would keep stale flags, and one that cleared cause on every event would lose its history. It raises a trap from a cause bit left over by an earlier overflow while the current operation reports only inexact. A design that gated the trap on the new exceptions alone would stay silent there. Unordered compares must keep T, and a design that cleared T on them would be caught. A load colliding with a trapping event must leave no trap and no flag behind, and a design with the priority reversed would fail that check.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int CSR_W     = 32;
  localparam int EXC_W     = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = 7;
  localparam int CAUSE_LSB = 12;
  localparam int CAUSE_W   = 6;
  localparam int DN_BIT    = 18;
  localparam int USED_W    = DN_BIT + 1;
  localparam logic [CSR_W-1:0] LOAD_MASK = CSR_W'((64'd1 << USED_W) - 64'd1);
  localparam logic [RM_W-1:0]  RM_TRUNC  = 2'b01;
  localparam int VEC_W = 12;
  localparam logic [VEC_W-1:0] TRAP_CODE = 12'h120;

  typedef enum logic [1:0] {
    EV_ARITH  = 2'd0,
    EV_CMP_EQ = 2'd1,
    EV_CMP_GT = 2'd2,
    EV_RSVD   = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;
endpackage

// File: rtl/fsr_event_unit.sv
module fsr_event_unit
  import fsr_pkg::*;
(
  input  logic [CSR_W-1:0] csr,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [1:0]       ev_rel,
  input  logic [EXC_W-1:0] ev_exc,
  output logic [CSR_W-1:0] csr_nxt,
  output logic             trap,
  output logic             t_we,
  output logic             t_val
);
  logic             is_cmp;
  logic             do_status;
  logic [EXC_W-1:0] cause_acc;

  assign is_cmp    = (ev_kind == EV_CMP_EQ) || (ev_kind == EV_CMP_GT);
  assign do_status = ev_valid && (!is_cmp || ev_rel == REL_UN);
  assign cause_acc = csr[CAUSE_LSB +: EXC_W] | ev_exc;

  always_comb begin
    csr_nxt = csr;
    trap    = 1'b0;
    if (do_status) begin
      csr_nxt[FLAG_LSB +: EXC_W] = ev_exc;
      if (|ev_exc) begin
        csr_nxt[CAUSE_LSB +: EXC_W] = cause_acc;
        trap = |(cause_acc & csr[EN_LSB +: EXC_W]);
      end
    end
  end

  always_comb begin
    t_we  = ev_valid && is_cmp && (ev_rel != REL_UN);
    t_val = (ev_kind == EV_CMP_EQ) ? (ev_rel == REL_EQ) : (ev_rel == REL_GT);
  end
endmodule

// File: rtl/fsr_mode_decode.sv
module fsr_mode_decode
  import fsr_pkg::*;
(
  input  logic [CSR_W-1:0] csr,
  output logic             round_trunc,
  output logic             flush_zero
);
  assign round_trunc = (csr[RM_LSB +: RM_W] == RM_TRUNC);
  assign flush_zero  = csr[DN_BIT];
endmodule

// File: rtl/fsr_tbit.sv
module fsr_tbit (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic we,
  input  logic val,
  output logic t_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      t_q <= 1'b0;
    else if (we && !hold)
      t_q <= val;
  end
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [31:0]      sw_wdata,
  input  logic [31:0]      sw_wmask,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [1:0]       ev_rel,
  input  logic [4:0]       ev_exc,
  output logic [31:0]      csr_q,
  output logic             round_trunc,
  output logic             flush_zero,
  output logic             trap_req,
  output logic [11:0]      trap_vec,
  output logic             t_bit
);
  logic [CSR_W-1:0] ev_nxt;
  logic [CSR_W-1:0] sw_nxt;
  logic             ev_trap;
  logic             t_we;
  logic             t_val;

  fsr_event_unit u_event (
    .csr      (csr_q),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .ev_rel   (ev_rel),
    .ev_exc   (ev_exc),
    .csr_nxt  (ev_nxt),
    .trap     (ev_trap),
    .t_we     (t_we),
    .t_val    (t_val)
  );

  assign sw_nxt = ((csr_q & ~sw_wmask) | (sw_wdata & sw_wmask)) & LOAD_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q    <= '0;
      trap_req <= 1'b0;
    end else begin
      csr_q    <= sw_we ? sw_nxt : ev_nxt;
      trap_req <= ev_trap && !sw_we;
    end
  end

  assign trap_vec = trap_req ? TRAP_CODE : '0;

  fsr_mode_decode u_decode (
    .csr         (csr_q),
    .round_trunc (round_trunc),
    .flush_zero  (flush_zero)
  );

  fsr_tbit u_tbit (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (sw_we),
    .we    (t_we),
    .val   (t_val),
    .t_q   (t_bit)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sw_we,
  input logic [31:0] sw_wdata,
  input logic [31:0] sw_wmask,
  input logic        ev_valid,
  input logic [1:0]  ev_kind,
  input logic [1:0]  ev_rel,
  input logic [4:0]  ev_exc,
  input logic [31:0] csr_q,
  input logic        round_trunc,
  input logic        flush_zero,
  input logic        trap_req,
  input logic [11:0] trap_vec,
  input logic        t_bit
);
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[31:USED_W] == '0);

  assert_trunc_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    round_trunc == (csr_q[1:0] == 2'b01));

  assert_flush_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_zero == csr_q[DN_BIT]);

  assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((csr_q[CAUSE_LSB +: EXC_W] & $past(csr_q[CAUSE_LSB +: EXC_W]))
                == $past(csr_q[CAUSE_LSB +: EXC_W])));

  assert_trap_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !sw_we && ev_exc == '0) |=> !trap_req);

  assert_unordered_t_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_rel == 2'd3) |=> $stable(t_bit));

  assert_load_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> !trap_req);

  assert_trap_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_vec == TRAP_CODE);

  assert_idle_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> trap_vec == '0);
endmodule

bind fp_status_reg fsr_checker i_chk (.*);

// File: tb/test_fp_status_reg.sv
module test_fp_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_wmask = '0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = '0;
  logic [1:0]  ev_rel = '0;
  logic [4:0]  ev_exc = '0;
  logic [31:0] csr_q;
  logic        round_trunc, flush_zero, trap_req, t_bit;
  logic [11:0] trap_vec;

  int n_total = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_status_reg i_fp_status_reg (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at the following negedge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    sw_we = 1'b0; ev_valid = 1'b0; ev_exc = '0;
  endtask

  task automatic load(input logic [31:0] d, input logic [31:0] m);
    sw_we = 1'b1; sw_wdata = d; sw_wmask = m;
    cycle();
  endtask

  task automatic event_in(input logic [1:0] k, input logic [1:0] r, input logic [4:0] e);
    ev_valid = 1'b1; ev_kind = k; ev_rel = r; ev_exc = e;
    cycle();
  endtask

  task automatic t_reset();
    chk("R1 reset word", csr_q, 32'h0);
    chk("R10 reset trap", {31'b0, trap_req}, 32'h0);
    chk("R7 reset T", {31'b0, t_bit}, 32'h0);
    chk("R2 reset rounding", {31'b0, round_trunc}, 32'h0);
  endtask

  task automatic t_load_modes();
    load(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R1 reserved masked", csr_q, 32'h0007_FFFF);
    chk("R2 mode 11 nearest", {31'b0, round_trunc}, 32'h0);
    chk("R3 flush set", {31'b0, flush_zero}, 32'h1);
    load(32'h0000_0001, 32'h0000_0003);
    chk("R1 masked partial load", csr_q, 32'h0007_FFFD);
    chk("R2 mode 01 truncate", {31'b0, round_trunc}, 32'h1);
    load(32'h0000_0000, 32'hFFFF_FFFF);
    chk("R3 flush clear", {31'b0, flush_zero}, 32'h0);
    chk("R2 mode 00 nearest", {31'b0, round_trunc}, 32'h0);
  endtask

  task automatic t_flags_cause();
    event_in(2'd0, 2'd0, 5'b10010);
    chk("R4 flags from first op", csr_q, 32'h0001_2048);
    chk("R6 no enable no trap", {31'b0, trap_req}, 32'h0);
    event_in(2'd0, 2'd0, 5'b00001);
    chk("R5 cause accumulates", csr_q, 32'h0001_3004);
    event_in(2'd0, 2'd0, 5'b00000);
    chk("R4 R5 clean op clears flags keeps cause", csr_q, 32'h0001_3000);
  endtask

  task automatic t_trap();
    load(32'h0000_0200, 32'h0000_0F80);
    chk("R1 enable load", csr_q, 32'h0001_3200);
    event_in(2'd0, 2'd0, 5'b00100);
    chk("R6 overflow enabled word", csr_q, 32'h0001_7210);
    chk("R6 trap raised", {31'b0, trap_req}, 32'h1);
    chk("R10 trap vector", {20'b0, trap_vec}, 32'h120);
    @(negedge clk);
    chk("R10 trap one cycle", {31'b0, trap_req}, 32'h0);
    chk("R10 vector idle", {20'b0, trap_vec}, 32'h0);
    event_in(2'd0, 2'd0, 5'b00001);
    chk("R6 stale cause traps", {31'b0, trap_req}, 32'h1);
    chk("R6 stale cause word", csr_q, 32'h0001_7204);
  endtask

  task automatic t_compare();
    event_in(2'd1, 2'd1, 5'b0);
    chk("R7 eq holds", {31'b0, t_bit}, 32'h1);
    chk("R7 word untouched", csr_q, 32'h0001_7204);
    event_in(2'd2, 2'd1, 5'b0);
    chk("R7 gt fails on equal", {31'b0, t_bit}, 32'h0);
    event_in(2'd2, 2'd2, 5'b0);
    chk("R7 gt holds", {31'b0, t_bit}, 32'h1);
    event_in(2'd1, 2'd0, 5'b0);
    chk("R7 eq fails on less", {31'b0, t_bit}, 32'h0);
    event_in(2'd2, 2'd2, 5'b0);
    event_in(2'd1, 2'd3, 5'b10000);
    chk("R8 unordered keeps T", {31'b0, t_bit}, 32'h1);
    chk("R8 unordered flags", csr_q, 32'h0001_7240);
    chk("R8 unordered trap", {31'b0, trap_req}, 32'h1);
  endtask

  task automatic t_priority();
    sw_we = 1'b1; sw_wdata = 32'h0; sw_wmask = 32'hFFFF_FFFF;
    ev_valid = 1'b1; ev_kind = 2'd0; ev_rel = 2'd0; ev_exc = 5'b11111;
    cycle();
    chk("R9 load wins word", csr_q, 32'h0);
    chk("R9 no trap", {31'b0, trap_req}, 32'h0);
    sw_we = 1'b1; sw_wdata = 32'h0; sw_wmask = 32'h0;
    ev_valid = 1'b1; ev_kind = 2'd1; ev_rel = 2'd0;
    cycle();
    chk("R9 compare dropped", {31'b0, t_bit}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_modes();
    t_flags_cause();
    t_trap();
    t_compare();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule